// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block holds a small set of recent page-table entries and turns a virtual address into a physical address. The upper part of the address (the virtual page number) is compared against the tag of every entry at once. When one entry matches, the block returns that entry's physical page number with the low page-offset bits appended unchanged. When no entry matches, the block reports a miss. A page-table walker, or software, then services the miss and installs the new translation through the fill port.

Each entry also holds a two-bit permission field, a referenced flag and a dirty flag. A hitting access sets the referenced flag. A store that hits sets the dirty flag, because pages are only ever written back. An access that matches an entry whose permission forbids the operation is reported as a protection fault. A fault changes nothing in the table. A flush input drops every translation in a single cycle, for use on a process switch.

A lookup is presented for one cycle and its response appears in the next cycle. The response carries exactly one of hit, miss or fault. On a hit it also carries the entry's dirty and referenced flags as they stand after the access.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid and the round-robin pointer is 0. While no response is due, respValid, respHit, respMiss, respFault, respPaddr, respDirty and respRef are all 0.
- R2: A lookup whose page number matches a valid entry with sufficient permission gives respHit in the next cycle. respPaddr is then the entry's physical page number concatenated with the lookup's OFF_W offset bits, which pass through unchanged.
- R3: A lookup that matches no valid entry gives respMiss in the next cycle, with respPaddr, respDirty and respRef all 0.
- R4: In the permission field, bit 0 allows loads and bit 1 allows stores. A matching access whose bit is 0 gives respFault instead of a hit. respPaddr is then 0, respDirty and respRef show the entry's current flags, and the entry is left unchanged.
- R5: A hit sets the entry's referenced flag, and respRef is 1 in the hit response.
- R6: A store that hits sets the entry's dirty flag. respDirty reports it in that response and in every later response for the entry until it is replaced.
- R7: A fill installs the page number, physical page number and permission with dirty and referenced cleared, and takes effect from the next cycle. A fill whose page number is already present overwrites that entry rather than adding a second copy. A lookup in the same cycle as a fill sees the table as it was before the fill.
- R8: A fill whose page number is not present takes the lowest-indexed invalid entry when one exists.
- R9: A fill into a full table with no matching entry replaces the entry at the round-robin pointer. The pointer then advances by one, wrapping after ENTRIES-1. Flush does not move the pointer.
- R10: Flush invalidates every entry in one cycle. A lookup in the same cycle reports a miss and touches nothing. A fill in the same cycle is discarded.
- R11: respValid follows lookupValid by exactly one cycle. When respValid is 1, exactly one of respHit, respMiss and respFault is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all entries |
| lookupValid | input | 1 | Translation request this cycle |
| lookupStore | input | 1 | Request is a store (1) or a load (0) |
| lookupVaddr | input | VPN_W+OFF_W | Virtual address to translate |
| fillValid | input | 1 | Install a translation this cycle |
| fillVpn | input | VPN_W | Virtual page number to install |
| fillPpn | input | PPN_W | Physical page number to install |
| fillPerm | input | 2 | Permission: bit 0 load allowed, bit 1 store allowed |
| respValid | output | 1 | Response to the previous cycle's lookup |
| respHit | output | 1 | Translation succeeded |
| respMiss | output | 1 | No valid matching entry |
| respFault | output | 1 | Matching entry forbids the access |
| respPaddr | output | PPN_W+OFF_W | Physical address on a hit, otherwise 0 |
| respDirty | output | 1 | Entry's dirty flag after the access |
| respRef | output | 1 | Entry's referenced flag after the access |

## Verification
The bench keeps a small table of four entries and sweeps every virtual page number, both after a fill and after each change to the table. A wrong compare or a duplicated entry would show up there as a hit where a miss is due, or as the wrong physical page. Permission checks run loads and stores against read-only and write-only entries. A design that mixed up the permission bits would hit where it should fault, or would mark a faulting entry referenced. Eviction is traced through a full table: repeated fills, a flush in the middle, and a refill of the freed slots. A pointer that reset on flush, skipped, or ignored invalid slots would evict the wrong page, and the sweeps catch this. A flush combined with a lookup or a fill in the same cycle checks that the flush takes priority.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PERM_LOAD  = 0;
  localparam int PERM_STORE = 1;

  // Strobes from control to the entry datapath
  typedef struct packed {
    logic wrEn;      // install fill at wrIdx
    logic touchEn;   // set referenced on entry touchIdx
    logic setDirty;  // with touchEn: also set dirty
    logic showBits;  // fault: report current flags
    logic clrAll;    // flush every valid bit
  } ctrl_t;
endpackage

// File: rtl/tlb_dp.sv
module tlb_dp
  import tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 18,
  parameter int OFF_W = 12,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_t                  strobe,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [IDX_W-1:0]       touchIdx,
  input  logic [VPN_W-1:0]       lookVpn,
  input  logic [OFF_W-1:0]       lookOff,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [PPN_W-1:0]       fillPpn,
  input  logic [1:0]             fillPerm,
  output logic [N-1:0]           hitVec,
  output logic [N-1:0]           fillHitVec,
  output logic [N-1:0]           validVec,
  output logic [1:0]             selPerm,
  output logic [PPN_W+OFF_W-1:0] respPaddr,
  output logic                   respDirty,
  output logic                   respRef
);
  logic [VPN_W-1:0] tagQ   [N];
  logic [PPN_W-1:0] ppnQ   [N];
  logic [1:0]       permQ  [N];
  logic             validQ [N];
  logic             dirtyQ [N];
  logic             refQ   [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    assign hitVec[g]     = validQ[g] && (tagQ[g] == lookVpn);
    assign fillHitVec[g] = validQ[g] && (tagQ[g] == fillVpn);
    assign validVec[g]   = validQ[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tagQ[g]   <= '0;
        ppnQ[g]   <= '0;
        permQ[g]  <= '0;
        validQ[g] <= 1'b0;
        dirtyQ[g] <= 1'b0;
        refQ[g]   <= 1'b0;
      end else if (strobe.clrAll) begin
        validQ[g] <= 1'b0;
      end else if (strobe.wrEn && wrIdx == IDX_W'(g)) begin
        tagQ[g]   <= fillVpn;
        ppnQ[g]   <= fillPpn;
        permQ[g]  <= fillPerm;
        validQ[g] <= 1'b1;
        dirtyQ[g] <= 1'b0;
        refQ[g]   <= 1'b0;
      end else if (strobe.touchEn && touchIdx == IDX_W'(g)) begin
        refQ[g] <= 1'b1;
        if (strobe.setDirty) dirtyQ[g] <= 1'b1;
      end
    end
  end

  // Parallel select of the matching entry (at most one matches)
  logic [PPN_W-1:0] selPpn;
  logic             selDirty;
  logic             selRef;
  always_comb begin
    selPpn   = '0;
    selPerm  = '0;
    selDirty = 1'b0;
    selRef   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hitVec[i]) begin
        selPpn   = selPpn | ppnQ[i];
        selPerm  = selPerm | permQ[i];
        selDirty = selDirty | dirtyQ[i];
        selRef   = selRef | refQ[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respPaddr <= '0;
      respDirty <= 1'b0;
      respRef   <= 1'b0;
    end else begin
      respPaddr <= strobe.touchEn ? {selPpn, lookOff} : '0;
      respDirty <= (strobe.touchEn && (selDirty || strobe.setDirty)) ||
                   (strobe.showBits && selDirty);
      respRef   <= strobe.touchEn || (strobe.showBits && selRef);
    end
  end
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             lookupValid,
  input  logic             lookupStore,
  input  logic             fillValid,
  input  logic [N-1:0]     hitVec,
  input  logic [N-1:0]     fillHitVec,
  input  logic [N-1:0]     validVec,
  input  logic [1:0]       selPerm,
  output ctrl_t            strobe,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] touchIdx,
  output logic             respValid,
  output logic             respHit,
  output logic             respMiss,
  output logic             respFault
);
  function automatic logic [IDX_W-1:0] firstSet(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic [IDX_W-1:0] rrQ;
  logic anyHit, permOk, doHit, doFault, doMiss;
  logic fillHit, tableFull, useRr;

  assign anyHit  = |hitVec;
  assign permOk  = lookupStore ? selPerm[PERM_STORE] : selPerm[PERM_LOAD];
  assign doHit   = lookupValid && !flush && anyHit && permOk;
  assign doFault = lookupValid && !flush && anyHit && !permOk;
  assign doMiss  = lookupValid && !doHit && !doFault;

  assign fillHit   = |fillHitVec;
  assign tableFull = &validVec;
  assign useRr     = fillValid && !flush && !fillHit && tableFull;

  always_comb begin
    if (fillHit)         wrIdx = firstSet(fillHitVec);
    else if (!tableFull) wrIdx = firstSet(~validVec);
    else                 wrIdx = rrQ;
  end

  assign touchIdx        = firstSet(hitVec);
  assign strobe.wrEn     = fillValid && !flush;
  assign strobe.touchEn  = doHit;
  assign strobe.setDirty = doHit && lookupStore;
  assign strobe.showBits = doFault;
  assign strobe.clrAll   = flush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrQ       <= '0;
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respMiss  <= 1'b0;
      respFault <= 1'b0;
    end else begin
      if (useRr) rrQ <= (rrQ == IDX_W'(N - 1)) ? '0 : rrQ + 1'b1;
      respValid <= lookupValid;
      respHit   <= doHit;
      respMiss  <= doMiss;
      respFault <= doFault;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  parameter int OFF_W   = 12,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            flush,
  input  logic            lookupValid,
  input  logic            lookupStore,
  input  logic [VA_W-1:0] lookupVaddr,
  input  logic            fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic [1:0]      fillPerm,
  output logic            respValid,
  output logic            respHit,
  output logic            respMiss,
  output logic            respFault,
  output logic [PA_W-1:0] respPaddr,
  output logic            respDirty,
  output logic            respRef
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  ctrl_t              strobe;
  logic [IDX_W-1:0]   wrIdx, touchIdx;
  logic [ENTRIES-1:0] hitVec, fillHitVec, validVec;
  logic [1:0]         selPerm;

  tlb_ctrl #(.N(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush),
    .lookupValid(lookupValid), .lookupStore(lookupStore),
    .fillValid(fillValid), .hitVec(hitVec), .fillHitVec(fillHitVec),
    .validVec(validVec), .selPerm(selPerm), .strobe(strobe),
    .wrIdx(wrIdx), .touchIdx(touchIdx), .respValid(respValid),
    .respHit(respHit), .respMiss(respMiss), .respFault(respFault)
  );

  tlb_dp #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx),
    .touchIdx(touchIdx), .lookVpn(lookupVaddr[VA_W-1:OFF_W]),
    .lookOff(lookupVaddr[OFF_W-1:0]), .fillVpn(fillVpn),
    .fillPpn(fillPpn), .fillPerm(fillPerm), .hitVec(hitVec),
    .fillHitVec(fillHitVec), .validVec(validVec), .selPerm(selPerm),
    .respPaddr(respPaddr), .respDirty(respDirty), .respRef(respRef)
  );
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 18,
  parameter int OFF_W = 12
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   flush,
  input logic                   lookupValid,
  input logic                   lookupStore,
  input logic [VPN_W+OFF_W-1:0] lookupVaddr,
  input logic                   respValid,
  input logic                   respHit,
  input logic                   respMiss,
  input logic                   respFault,
  input logic [PPN_W+OFF_W-1:0] respPaddr,
  input logic                   respDirty,
  input logic                   respRef
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> (!respHit && !respMiss && !respFault && respPaddr == '0));

  a_r11_latency_on: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  a_r11_latency_off: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $onehot({respHit, respMiss, respFault}));

  a_r2_offset_pass: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (!respHit ||
      respPaddr[OFF_W-1:0] == $past(lookupVaddr[OFF_W-1:0])));

  a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    respMiss |-> (respPaddr == '0 && !respDirty && !respRef));

  a_r4_fault_zero: assert property (@(posedge clk) disable iff (!rstN)
    respFault |-> respPaddr == '0);

  a_r5_hit_ref: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respRef);

  a_r6_store_dirty: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && lookupStore) |=> (!respHit || respDirty));

  a_r10_flush_miss: assert property (@(posedge clk) disable iff (!rstN)
    (flush && lookupValid) |=> respMiss);
endmodule

bind tlb_xlate tlb_xlate_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .flush(flush), .lookupValid(lookupValid),
  .lookupStore(lookupStore), .lookupVaddr(lookupVaddr),
  .respValid(respValid), .respHit(respHit), .respMiss(respMiss),
  .respFault(respFault), .respPaddr(respPaddr), .respDirty(respDirty),
  .respRef(respRef)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  localparam int N  = 4;
  localparam int VW = 6;
  localparam int PW = 6;
  localparam int OW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic flush = 0, lookupValid = 0, lookupStore = 0, fillValid = 0;
  logic [VW+OW-1:0] lookupVaddr = '0;
  logic [VW-1:0] fillVpn = '0;
  logic [PW-1:0] fillPpn = '0;
  logic [1:0] fillPerm = '0;
  logic respValid, respHit, respMiss, respFault, respDirty, respRef;
  logic [PW+OW-1:0] respPaddr;

  tlb_xlate #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW), .OFF_W(OW)) i_tlb_xlate (
    .clk(clk), .rstN(rstN), .flush(flush), .lookupValid(lookupValid),
    .lookupStore(lookupStore), .lookupVaddr(lookupVaddr),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .fillPerm(fillPerm), .respValid(respValid), .respHit(respHit),
    .respMiss(respMiss), .respFault(respFault), .respPaddr(respPaddr),
    .respDirty(respDirty), .respRef(respRef)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // Reference table kept from the requirements
  logic [VW-1:0] mTag [N];
  logic [PW-1:0] mPpn [N];
  logic [1:0]    mPerm[N];
  bit mValid[N], mDirty[N], mRef[N];
  int mPtr = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ppnOf(input logic [VW-1:0] v);
    return PW'(v ^ 6'h2A);
  endfunction

  task automatic step(input bit look, input logic [VW-1:0] vpn, input logic [OW-1:0] off,
                      input bit st, input bit fl, input logic [VW-1:0] fv,
                      input logic [PW-1:0] fp, input logic [1:0] fperm,
                      input bit fsh, input string req);
    bit eH = 0, eM = 0, eF = 0, eD = 0, eR = 0, ok;
    logic [PW+OW-1:0] eP = '0;
    int idx = -1, vic = -1;
    lookupValid = look; lookupStore = st; lookupVaddr = {vpn, off};
    fillValid = fl; fillVpn = fv; fillPpn = fp; fillPerm = fperm; flush = fsh;
    if (fsh) begin
      eM = look;
      for (int i = 0; i < N; i++) mValid[i] = 0;
    end else begin
      if (look) begin
        for (int i = 0; i < N; i++) if (mValid[i] && mTag[i] == vpn) idx = i;
        if (idx < 0) eM = 1;
        else begin
          ok = st ? mPerm[idx][1] : mPerm[idx][0];
          if (ok) begin
            eH = 1; mRef[idx] = 1;
            if (st) mDirty[idx] = 1;
            eP = {mPpn[idx], off}; eD = mDirty[idx]; eR = 1;
          end else begin
            eF = 1; eD = mDirty[idx]; eR = mRef[idx];
          end
        end
      end
      if (fl) begin
        for (int i = 0; i < N; i++) if (mValid[i] && mTag[i] == fv) vic = i;
        if (vic < 0) for (int i = N - 1; i >= 0; i--) if (!mValid[i]) vic = i;
        if (vic < 0) begin vic = mPtr; mPtr = (mPtr + 1) % N; end
        mTag[vic] = fv; mPpn[vic] = fp; mPerm[vic] = fperm;
        mValid[vic] = 1; mDirty[vic] = 0; mRef[vic] = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    lookupValid = 0; fillValid = 0; flush = 0; lookupStore = 0;
    check({req, " R11 outcome"}, {28'd0, respValid, respHit, respMiss, respFault},
          {28'd0, look, eH, eM, eF});
    check({req, " data"}, {20'd0, respPaddr, respDirty, respRef}, {20'd0, eP, eD, eR});
  endtask

  task automatic fill(input logic [VW-1:0] v, input logic [1:0] perm, input string req);
    step(0, '0, '0, 0, 1, v, ppnOf(v), perm, 0, req);
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 64; v++) step(1, VW'(v), OW'(v * 5), 0, 0, '0, '0, '0, 0, req);
  endtask

  initial begin
    #(1_500_000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mValid[i] = 0; mDirty[i] = 0; mRef[i] = 0; mTag[i] = '0; mPpn[i] = '0; mPerm[i] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {24'd0, respValid, respHit, respMiss, respFault,
          respDirty, respRef, 2'b0}, 32'd0);
    check("R1 reset paddr", 32'(respPaddr), 32'd0);
    rstN = 1;
    @(negedge clk);
    step(1, 6'd5, 4'd3, 0, 0, '0, '0, '0, 0, "R1 empty miss");

    // R7 R8: fill an empty table, lowest invalid first
    fill(6'd5, 2'b11, "R8 fill");
    fill(6'd9, 2'b11, "R8 fill");
    fill(6'd20, 2'b11, "R8 fill");
    fill(6'd33, 2'b11, "R8 fill");
    sweep("R2 R3 sweep full");

    // R5 R6: referenced and dirty flags
    step(1, 6'd9, 4'hA, 1, 0, '0, '0, '0, 0, "R6 store hit");
    step(1, 6'd9, 4'h1, 0, 0, '0, '0, '0, 0, "R6 dirty kept");
    step(1, 6'd5, 4'h2, 0, 0, '0, '0, '0, 0, "R5 load ref");

    // R7 same-page refill replaces; R4 permissions
    fill(6'd20, 2'b01, "R7 refill readonly");
    step(1, 6'd20, 4'h4, 1, 0, '0, '0, '0, 0, "R4 store fault");
    step(1, 6'd20, 4'h4, 0, 0, '0, '0, '0, 0, "R4 load ok after fault");
    step(1, 6'd20, 4'h4, 1, 0, '0, '0, '0, 0, "R4 fault shows ref");
    fill(6'd33, 2'b10, "R7 refill writeonly");
    step(1, 6'd33, 4'h7, 0, 0, '0, '0, '0, 0, "R4 load fault");
    step(1, 6'd33, 4'h7, 1, 0, '0, '0, '0, 0, "R4 store ok");
    fill(6'd9, 2'b00, "R7 refill noaccess");
    step(1, 6'd9, 4'h0, 0, 0, '0, '0, '0, 0, "R7 flags cleared fault");
    sweep("R7 sweep no duplicate");

    // R9: round robin across a full table
    fill(6'd40, 2'b11, "R9 rr");
    fill(6'd41, 2'b11, "R9 rr");
    sweep("R9 sweep after two");
    fill(6'd42, 2'b11, "R9 rr");
    fill(6'd43, 2'b11, "R9 rr");
    fill(6'd44, 2'b11, "R9 rr wrap");
    sweep("R9 sweep after wrap");

    // R7 lookup concurrent with fill of same page
    step(1, 6'd50, 4'h9, 0, 1, 6'd50, ppnOf(6'd50), 2'b11, 0, "R7 same-cycle lookup");
    step(1, 6'd50, 4'h9, 0, 0, '0, '0, '0, 0, "R7 next-cycle hit");

    // R10 flush
    step(1, 6'd50, 4'h3, 0, 0, '0, '0, '0, 1, "R10 flush with lookup");
    sweep("R10 sweep after flush");
    step(0, '0, '0, 0, 1, 6'd12, ppnOf(6'd12), 2'b11, 1, "R10 flush with fill");
    step(1, 6'd12, 4'h0, 0, 0, '0, '0, '0, 0, "R10 fill discarded");

    // R8 R9 refill after flush, pointer kept
    fill(6'd1, 2'b11, "R8 refill");
    fill(6'd2, 2'b11, "R8 refill");
    fill(6'd3, 2'b11, "R8 refill");
    fill(6'd4, 2'b11, "R8 refill");
    fill(6'd60, 2'b11, "R9 pointer kept");
    sweep("R9 sweep final");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule